// File: doc/BRIEF.md
# Guardband Sweep Test Controller

This block sequences one periodic self-test of a core. After `start`, it launches the same functional test run several times. Each run returns a fingerprint, a hash of internal state. Between runs the block shortens a clock-period setting, which leaves less timing slack with each step. The first fingerprint of a test period becomes that period's reference. Every later run must reproduce the reference. The period ends at the first fingerprint that differs from the reference, or after a matching run at the shortest setting.

At the end of each period the block records a threshold: the shortest setting that still matched. Over successive periods it watches for that threshold to creep toward longer, less stressed settings. When the threshold rises in two periods in a row, the block raises a sticky wearout flag. The block only produces the setting value. Turning that value into a real clock or supply change is the job of other logic.

Fingerprints arrive on a valid/ready channel. `fp_ready` is high only while the block waits for the result of the run it launched. A source that raises `fp_valid` while `fp_ready` is low must hold `fp_valid` and `fp_data` steady until the transfer happens. One transfer completes each run. Start, run-start, setting, threshold, done and wearout are plain control and status pins.

Top module: `gb_sweep_ctrl`

## Requirements
- R1: Reset state. `run_start`, `fp_ready`, `sweep_done` and `wearout` are 0. `cond_period` and `thr_period` are 955 (the longest setting).
- R2: When `start` is high in the idle state, a test period begins. `run_start` pulses for exactly one cycle per run, and the first run uses setting 955.
- R3: `fp_ready` is high only between a run's start pulse and the acceptance of that run's fingerprint. A fingerprint transfers on a cycle where `fp_valid` and `fp_ready` are both high. Exactly one fingerprint is taken per run, whatever the source delay.
- R4: The first fingerprint of a period is the reference. After each matching run the setting drops by 5, so run k (counting from 0) uses setting 955 - 5k.
- R5: The first run whose fingerprint differs from the reference ends the period. The threshold becomes the setting of the run before it, which is 955 when run 1 fails.
- R6: If all 12 runs through setting 900 match, the period ends after the run at 900 and the threshold is 900.
- R7: `sweep_done` is a one-cycle pulse at the end of each period. `thr_period` changes only in that cycle.
- R8: A period whose threshold is larger than the previous period's threshold counts as a drift. An equal or smaller threshold clears the drift count. The first period after reset is never a drift. `wearout` rises at the end of the second drift in a row.
- R9: Once set, `wearout` stays 1 until reset, whatever later periods record.
- R10: `start` is ignored while a period is in progress. The runs and settings continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test period (used only when idle) |
| fp_valid | input | 1 | Fingerprint of the current run is offered |
| fp_ready | output | 1 | Block accepts a fingerprint |
| fp_data | input | 16 | Fingerprint value |
| run_start | output | 1 | One-cycle pulse launching a test run |
| cond_period | output | 10 | Clock-period setting in ps for the current run |
| thr_period | output | 10 | Shortest matching setting of the last period |
| sweep_done | output | 1 | One-cycle pulse at the end of a period |
| wearout | output | 1 | Sticky wearout flag |

## Verification
The embedded properties assume a well-behaved fingerprint source. Once it raises `fp_valid`, it keeps `fp_valid` and `fp_data` unchanged until `fp_ready` takes the value. The stimulus honours this: it presents a fingerprint only after the matching run-start pulse, holds it through a delay of zero to two cycles, and drops it after the accepting edge. Mismatches are injected at chosen run indices, and threshold sequences are picked to create single, broken and consecutive drifts.

// File: rtl/gb_sweep_pkg.sv
package gb_sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT_DONE,
    ST_COMPARE,
    ST_STEP,
    ST_FINISH
  } sweep_state_e;
endpackage

// File: rtl/gb_sweep_seq.sv
module gb_sweep_seq
  import gb_sweep_pkg::*;
#(
  parameter int SET_W  = 10,
  parameter int P_MAX  = 955,
  parameter int P_MIN  = 900,
  parameter int P_STEP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fp_valid,
  input  logic             fp_match,
  output logic             run_start,
  output logic             fp_ready,
  output logic             fp_load,
  output logic             ref_load,
  output logic [SET_W-1:0] cond_o,
  output logic             fin_o,
  output logic [SET_W-1:0] fin_thr_o
);
  localparam logic [SET_W-1:0] MAX_V  = SET_W'(P_MAX);
  localparam logic [SET_W-1:0] MIN_V  = SET_W'(P_MIN);
  localparam logic [SET_W-1:0] STEP_V = SET_W'(P_STEP);

  sweep_state_e     state_q;
  logic [SET_W-1:0] cond_q;
  logic [SET_W-1:0] thr_q;
  logic             first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cond_q  <= MAX_V;
      thr_q   <= MAX_V;
      first_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          cond_q  <= MAX_V;
          first_q <= 1'b1;
        end
        ST_RUN: state_q <= ST_WAIT_DONE;
        ST_WAIT_DONE: if (fp_valid) state_q <= ST_COMPARE;
        ST_COMPARE: begin
          first_q <= 1'b0;
          if (!first_q && !fp_match) begin
            thr_q   <= cond_q + STEP_V;
            state_q <= ST_FINISH;
          end else if (cond_q <= MIN_V) begin
            thr_q   <= cond_q;
            state_q <= ST_FINISH;
          end else begin
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          cond_q  <= cond_q - STEP_V;
          state_q <= ST_RUN;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_start = (state_q == ST_RUN);
  assign fp_ready  = (state_q == ST_WAIT_DONE);
  assign fp_load   = fp_ready && fp_valid;
  assign ref_load  = (state_q == ST_COMPARE) && first_q;
  assign cond_o    = cond_q;
  assign fin_o     = (state_q == ST_FINISH);
  assign fin_thr_o = thr_q;

  // R2: a launch pulse never lasts two cycles
  p_run_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);
  // R3: a launched run is always followed by a wait for its result
  p_run_then_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> fp_ready);
  // R4: the setting only moves down by one step or back to the start
  p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q != $past(cond_q)) |-> (cond_q == $past(cond_q) - STEP_V || cond_q == MAX_V));
  // R4: the setting stays inside the sweep window
  p_cond_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q >= MIN_V) && (cond_q <= MAX_V));
  // R10: start does not restart a period that is in flight
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE && state_q != ST_STEP) |=> $stable(cond_q));
endmodule

// File: rtl/gb_fp_compare.sv
module gb_fp_compare #(
  parameter int FP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_valid,
  input  logic            fp_ready,
  input  logic [FP_W-1:0] fp_data,
  input  logic            fp_load,
  input  logic            ref_load,
  output logic            fp_match
);
  logic [FP_W-1:0] run_fp_q;
  logic [FP_W-1:0] ref_fp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_fp_q <= '0;
      ref_fp_q <= '0;
    end else begin
      if (fp_load)  run_fp_q <= fp_data;
      if (ref_load) ref_fp_q <= run_fp_q;
    end
  end

  assign fp_match = (run_fp_q == ref_fp_q);

  // R3: source holds an offered fingerprint until it is taken
  p_fp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && !fp_ready) |=> (fp_valid && $stable(fp_data)));
endmodule

// File: rtl/gb_drift_track.sv
module gb_drift_track #(
  parameter int SET_W      = 10,
  parameter int P_MAX      = 955,
  parameter int DRIFT_RUNS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [SET_W-1:0] fin_thr,
  output logic [SET_W-1:0] thr_o,
  output logic             done_o,
  output logic             wear_o
);
  localparam int CNT_W = $clog2(DRIFT_RUNS + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DRIFT_RUNS);

  logic [SET_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             have_prev_q;
  logic             done_q;
  logic             wear_q;
  logic             drift;

  assign drift = have_prev_q && (fin_thr > thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q       <= SET_W'(P_MAX);
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      wear_q      <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        thr_q       <= fin_thr;
        have_prev_q <= 1'b1;
        if (drift) begin
          if (cnt_q < CNT_LIM) cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 >= CNT_LIM) wear_q <= 1'b1;
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign thr_o  = thr_q;
  assign done_o = done_q;
  assign wear_o = wear_q;

  // R7: end-of-period pulse is one cycle wide
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: the threshold changes only together with the done pulse
  p_thr_only_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != $past(thr_q)) |-> done_q);
  // R9: wearout never clears without reset
  p_wear_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wear_q |=> wear_q);
  // R8: wearout can only rise at the end of a period
  p_wear_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wear_q) |-> done_q);
endmodule

// File: rtl/gb_sweep_ctrl.sv
module gb_sweep_ctrl #(
  parameter int FP_W       = 16,
  parameter int SET_W      = 10,
  parameter int P_MAX      = 955,
  parameter int P_MIN      = 900,
  parameter int P_STEP     = 5,
  parameter int DRIFT_RUNS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fp_valid,
  output logic             fp_ready,
  input  logic [FP_W-1:0]  fp_data,
  output logic             run_start,
  output logic [SET_W-1:0] cond_period,
  output logic [SET_W-1:0] thr_period,
  output logic             sweep_done,
  output logic             wearout
);
  logic             fp_match;
  logic             fp_load;
  logic             ref_load;
  logic             fin;
  logic [SET_W-1:0] fin_thr;

  gb_sweep_seq #(
    .SET_W(SET_W), .P_MAX(P_MAX), .P_MIN(P_MIN), .P_STEP(P_STEP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fp_valid(fp_valid),
    .fp_match(fp_match), .run_start(run_start), .fp_ready(fp_ready),
    .fp_load(fp_load), .ref_load(ref_load), .cond_o(cond_period),
    .fin_o(fin), .fin_thr_o(fin_thr)
  );

  gb_fp_compare #(.FP_W(FP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_data(fp_data), .fp_load(fp_load), .ref_load(ref_load),
    .fp_match(fp_match)
  );

  gb_drift_track #(
    .SET_W(SET_W), .P_MAX(P_MAX), .DRIFT_RUNS(DRIFT_RUNS)
  ) u_drift (
    .clk(clk), .rst_n(rst_n), .fin(fin), .fin_thr(fin_thr),
    .thr_o(thr_period), .done_o(sweep_done), .wear_o(wearout)
  );
endmodule

// File: tb/gb_sweep_ctrl_tb.sv
module gb_sweep_ctrl_tb;
  localparam logic [15:0] GOOD = 16'hA5C3;
  localparam logic [15:0] BAD  = 16'hA5C2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fp_valid = 1'b0;
  logic [15:0] fp_data = '0;
  logic        fp_ready, run_start, sweep_done, wearout;
  logic [9:0]  cond_period, thr_period;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gb_sweep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fp_valid(fp_valid),
    .fp_ready(fp_ready), .fp_data(fp_data), .run_start(run_start),
    .cond_period(cond_period), .thr_period(thr_period),
    .sweep_done(sweep_done), .wearout(wearout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; fp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one test period; runs with index >= fail_k return a differing fingerprint
  task automatic run_period(input int fail_k, input bit mid_start,
                            output int runs, output int thr);
    int delay = 0;
    bit pending = 0;
    bit sent = 0;
    bit cond_ok = 1;
    runs = 0; thr = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (sent) begin fp_valid = 1'b0; sent = 0; end
      start = (mid_start && cyc == 9);
      if (run_start) begin
        if (cond_period != 10'(955 - 5 * runs)) cond_ok = 0;
        if (fp_ready) cond_ok = 0;
        runs++; pending = 1; delay = runs % 3;
      end
      if (pending) begin
        if (delay > 0) delay--;
        else begin
          fp_valid = 1'b1;
          fp_data  = (runs - 1 >= fail_k) ? BAD : GOOD;
          pending  = 0;
        end
      end
      if (fp_valid && fp_ready) sent = 1;
      if (sweep_done) begin thr = int'(thr_period); break; end
      @(negedge clk);
    end
    start = 1'b0;
    check(cond_ok, "R4 setting per run / R3 ready low at launch", cond_ok, 1);
    @(negedge clk);
    check(!sweep_done, "R7 done pulse width", sweep_done, 0);
    check(!fp_ready, "R3 ready low when idle", fp_ready, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(run_start == 0 && fp_ready == 0 && sweep_done == 0, "R1 control outputs",
          {run_start, fp_ready, sweep_done}, 0);
    check(wearout == 0, "R1 wearout", wearout, 0);
    check(cond_period == 955, "R1 setting", cond_period, 955);
    check(thr_period == 955, "R1 threshold", thr_period, 955);
  endtask

  task automatic t_sweep_shapes();
    int runs, thr;
    run_period(99, 0, runs, thr);
    check(thr == 900, "R6 full pass threshold", thr, 900);
    check(runs == 12, "R6 full pass run count", runs, 12);
    run_period(1, 0, runs, thr);
    check(thr == 955, "R5 fail at second run", thr, 955);
    check(runs == 2, "R5 runs until first mismatch", runs, 2);
    check(wearout == 0, "R8 single drift no flag", wearout, 0);
    run_period(11, 1, runs, thr);
    check(thr == 905, "R5 fail at last run", thr, 905);
    check(runs == 12, "R10 start mid-period ignored", runs, 12);
    check(wearout == 0, "R8 drift broken", wearout, 0);
  endtask

  task automatic t_drift();
    int runs, thr;
    do_reset();
    run_period(8, 0, runs, thr);
    check(thr == 920 && runs == 9, "R5 threshold 920", thr, 920);
    check(wearout == 0, "R8 first period not a drift", wearout, 0);
    run_period(7, 0, runs, thr);
    check(thr == 925, "R5 threshold 925", thr, 925);
    check(wearout == 0, "R8 one drift", wearout, 0);
    run_period(6, 0, runs, thr);
    check(thr == 930 && runs == 7, "R5 threshold 930", thr, 930);
    check(wearout == 1, "R8 two consecutive drifts", wearout, 1);
    run_period(99, 0, runs, thr);
    check(thr == 900, "R6 pass after wearout", thr, 900);
    check(wearout == 1, "R9 wearout sticky", wearout, 1);
    do_reset();
    check(wearout == 0, "R9 cleared by reset", wearout, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep_shapes();
    t_drift();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule